// File: doc/BRIEF.md
# Configuration Frame Address Sequencer

This block keeps the address of the configuration frame being loaded. It moves that address through the configuration memory while frame data streams in. Each accepted 32-bit data word is counted. When the last word of a frame arrives, the address steps to the next frame. The step is a chained carry: the minor field counts first, then the column field, then the row field, then the half-select bit, and the block-type field counts last. Each field returns to zero once it passes its own limit. The minor limit depends on the current block type. The column and row limits are parameters.

A loader that parses configuration packets drives this block. It writes a start address through the write port, normally zero, and then offers data words through a valid/enable pair. The block reports the current frame address. It raises a one-cycle done flag once the last frame of the RAM-content block type is complete. After that it refuses further words until a new address is written.

Top module: `cfg_frame_addr_seq`

## Requirements
- R1: After reset, `frame_addr` is 0, `word_ready` is 1 and `seq_done` is 0.
- R2: The address has 23 bits. Bit 22 is the half select, bits 21:19 the block type, bits 18:14 the row, bits 13:6 the column and bits 5:0 the minor. A write (`wr_en` high) loads `wr_addr` at the next edge in any state. It also restarts the in-frame word count at zero, so a full `FRAME_WORDS` words are needed after it.
- R3: The address stays unchanged until exactly `FRAME_WORDS` (default 41) words have been accepted. It steps at the edge that accepts the last of them.
- R4: A word is accepted only on a cycle where `word_valid`, `word_enable` and `word_ready` are all high. Any other combination leaves the address and the word count unchanged.
- R5: The minor field returns to 0 and carries into the column once it reaches its limit. The limit is selected by block type: `MINOR_LAST_T0` for type 000 (logic/IO/clock), `MINOR_LAST_T1` for type 001 (RAM interconnect) and `MINOR_LAST_T2` for type 010 (RAM content). Below the limit, the minor field simply increments.
- R6: On a carry, the column field returns to 0 at `COL_LAST` and carries into the row. The row field returns to 0 at `ROW_LAST` and carries into the half bit.
- R7: A carry out of the half bit (going from 1 back to 0) increments the block type and leaves all lower fields at 0.
- R8: When the final frame of type 010 completes (half 1, row, column and minor all at their limits), `seq_done` is high for exactly one cycle. The address holds that final frame and `word_ready` goes low. Later words are ignored until a write.
- R9: A write and a data word in the same cycle: the write wins and the word is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Direct address write strobe |
| wr_addr | input | 23 | Address value to load |
| word_valid | input | 1 | A data word is offered |
| word_enable | input | 1 | Data words may be counted this cycle |
| word_ready | output | 1 | Block accepts words (low after the sequence ends) |
| frame_addr | output | 23 | Current frame address |
| seq_done | output | 1 | One-cycle pulse at the end of the normal sequence |

## Verification
Every result is registered once. A write shows on `frame_addr` one edge after `wr_en` is seen. The address step, the done pulse and the drop of `word_ready` all show one edge after the last word of a frame is accepted. The bench drives inputs on the falling edge. Each helper task returns on the falling edge after its last stimulus edge, and the checks sample there. This lands exactly in the one-cycle window in which `seq_done` is high. Checks of held state are made after 40 words and again after the 41st, which separates a frame that ends early from one that ends late.

// File: rtl/cfa_pkg.sv
package cfa_pkg;
   localparam int MINOR_W = 6;
   localparam int COL_W   = 8;
   localparam int ROW_W   = 5;
   localparam int TYPE_W  = 3;
   localparam int FA_W    = 1 + TYPE_W + ROW_W + COL_W + MINOR_W;

   typedef enum logic [TYPE_W-1:0] {
      BT_LOGIC    = 3'd0,
      BT_RAM_IC   = 3'd1,
      BT_RAM_DATA = 3'd2,
      BT_CFG_A    = 3'd3,
      BT_CFG_B    = 3'd4
   } blk_type_e;

   typedef struct packed {
      logic               half;
      logic [TYPE_W-1:0]  btype;
      logic [ROW_W-1:0]   row;
      logic [COL_W-1:0]   col;
      logic [MINOR_W-1:0] minor;
   } frame_addr_t;
endpackage

// File: rtl/cfa_word_counter.sv
module cfa_word_counter #(
   parameter int FRAME_WORDS = 41,
   localparam int CNT_W = (FRAME_WORDS > 1) ? $clog2(FRAME_WORDS) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic step,
   output logic frame_end
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_WORDS - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             at_last;

   assign at_last   = (cnt_q == LAST);
   assign frame_end = step && at_last;

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         cnt_q <= '0;
      end else if (step) begin
         cnt_q <= at_last ? '0 : cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/cfa_field_step.sv
module cfa_field_step #(
   parameter int W = 6
) (
   input  logic [W-1:0] val,
   input  logic [W-1:0] last,
   input  logic         inc,
   output logic [W-1:0] nxt,
   output logic         carry
);
   logic wrap;

   assign wrap  = (val >= last);
   assign carry = inc && wrap;

   always_comb begin
      if (!inc)      nxt = val;
      else if (wrap) nxt = '0;
      else           nxt = val + 1'b1;
   end
endmodule

// File: rtl/cfa_minor_limit.sv
module cfa_minor_limit
   import cfa_pkg::*;
#(
   parameter int MINOR_LAST_T0 = 21,
   parameter int MINOR_LAST_T1 = 19,
   parameter int MINOR_LAST_T2 = 63,
   parameter int MINOR_LAST_T3 = 21,
   parameter int MINOR_LAST_T4 = 19
) (
   input  logic [TYPE_W-1:0]  btype,
   output logic [MINOR_W-1:0] last
);
   always_comb begin
      case (btype)
         BT_RAM_IC:   last = MINOR_W'(MINOR_LAST_T1);
         BT_RAM_DATA: last = MINOR_W'(MINOR_LAST_T2);
         BT_CFG_A:    last = MINOR_W'(MINOR_LAST_T3);
         BT_CFG_B:    last = MINOR_W'(MINOR_LAST_T4);
         default:     last = MINOR_W'(MINOR_LAST_T0);
      endcase
   end
endmodule

// File: rtl/cfg_frame_addr_seq.sv
module cfg_frame_addr_seq
   import cfa_pkg::*;
#(
   parameter int FRAME_WORDS   = 41,
   parameter int COL_LAST      = 15,
   parameter int ROW_LAST      = 3,
   parameter int TYPE_LAST     = 4,
   parameter int MINOR_LAST_T0 = 21,
   parameter int MINOR_LAST_T1 = 19,
   parameter int MINOR_LAST_T2 = 63,
   parameter int MINOR_LAST_T3 = 21,
   parameter int MINOR_LAST_T4 = 19
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [FA_W-1:0] wr_addr,
   input  logic            word_valid,
   input  logic            word_enable,
   output logic            word_ready,
   output logic [FA_W-1:0] frame_addr,
   output logic            seq_done
);
   localparam int MINOR_MAX = (1 << MINOR_W) - 1;

   // elaboration-time parameter checks
   if (FRAME_WORDS < 2) begin : g_bad_frame
      $error("FRAME_WORDS must be at least 2");
   end
   if (COL_LAST < 0 || COL_LAST >= (1 << COL_W)) begin : g_bad_col
      $error("COL_LAST out of field range");
   end
   if (ROW_LAST < 0 || ROW_LAST >= (1 << ROW_W)) begin : g_bad_row
      $error("ROW_LAST out of field range");
   end
   if (TYPE_LAST < int'(BT_RAM_DATA) || TYPE_LAST >= (1 << TYPE_W)) begin : g_bad_type
      $error("TYPE_LAST must cover the RAM content type");
   end
   if (MINOR_LAST_T0 > MINOR_MAX || MINOR_LAST_T1 > MINOR_MAX ||
       MINOR_LAST_T2 > MINOR_MAX || MINOR_LAST_T3 > MINOR_MAX ||
       MINOR_LAST_T4 > MINOR_MAX) begin : g_bad_minor
      $error("minor limit exceeds field range");
   end

   frame_addr_t cur_q, nxt;
   logic        halt_q, done_q;
   logic        accept, frame_end, final_frame;
   logic        c_minor, c_col, c_row, c_half, c_type;
   logic [MINOR_W-1:0] minor_last;

   assign accept = word_valid && word_enable && !halt_q && !wr_en;

   cfa_word_counter #(.FRAME_WORDS(FRAME_WORDS)) u_wcnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (wr_en),
      .step      (accept),
      .frame_end (frame_end)
   );

   cfa_minor_limit #(
      .MINOR_LAST_T0(MINOR_LAST_T0), .MINOR_LAST_T1(MINOR_LAST_T1),
      .MINOR_LAST_T2(MINOR_LAST_T2), .MINOR_LAST_T3(MINOR_LAST_T3),
      .MINOR_LAST_T4(MINOR_LAST_T4)
   ) u_mlim (
      .btype (cur_q.btype),
      .last  (minor_last)
   );

   // carry chain: minor -> column -> row -> half -> block type
   cfa_field_step #(.W(MINOR_W)) u_minor (
      .val(cur_q.minor), .last(minor_last), .inc(frame_end),
      .nxt(nxt.minor), .carry(c_minor)
   );
   cfa_field_step #(.W(COL_W)) u_col (
      .val(cur_q.col), .last(COL_W'(COL_LAST)), .inc(c_minor),
      .nxt(nxt.col), .carry(c_col)
   );
   cfa_field_step #(.W(ROW_W)) u_row (
      .val(cur_q.row), .last(ROW_W'(ROW_LAST)), .inc(c_col),
      .nxt(nxt.row), .carry(c_row)
   );
   cfa_field_step #(.W(1)) u_half (
      .val(cur_q.half), .last(1'b1), .inc(c_row),
      .nxt(nxt.half), .carry(c_half)
   );
   cfa_field_step #(.W(TYPE_W)) u_type (
      .val(cur_q.btype), .last(TYPE_W'(TYPE_LAST)), .inc(c_half),
      .nxt(nxt.btype), .carry(c_type)
   );

   assign final_frame = c_half && (cur_q.btype == BT_RAM_DATA);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_q  <= '0;
         halt_q <= 1'b0;
         done_q <= 1'b0;
      end else if (wr_en) begin
         cur_q  <= frame_addr_t'(wr_addr);
         halt_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= final_frame;
         if (final_frame) begin
            halt_q <= 1'b1;
         end else if (frame_end) begin
            cur_q <= nxt;
         end
      end
   end

   assign frame_addr = cur_q;
   assign word_ready = !halt_q;
   assign seq_done   = done_q;

   logic unused_carry;
   assign unused_carry = c_type;
endmodule

// File: rtl/cfa_checker.sv
module cfa_checker #(
   parameter int FRAME_WORDS = 41,
   parameter int FA_W = 23
) (
   input logic            clk,
   input logic            rst_n,
   input logic            wr_en,
   input logic [FA_W-1:0] wr_addr,
   input logic            word_valid,
   input logic            word_enable,
   input logic            word_ready,
   input logic [FA_W-1:0] frame_addr,
   input logic            seq_done
);
   logic acc;
   int   seen_q;

   assign acc = word_valid && word_enable && word_ready && !wr_en;

   always_ff @(posedge clk) begin
      if (!rst_n || wr_en)  seen_q <= 0;
      else if (acc)         seen_q <= (seen_q == FRAME_WORDS - 1) ? 0 : seen_q + 1;
   end

   p_write_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> frame_addr == $past(wr_addr));
   p_write_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> word_ready);
   p_midframe_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && seen_q != FRAME_WORDS - 1) |=> $stable(frame_addr));
   p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !(word_valid && word_enable)) |=> ($stable(frame_addr) && !seq_done));
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done |=> !seq_done);
   p_done_halts_r8: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done |-> !word_ready);
   p_halted_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!word_ready && !wr_en) |=> ($stable(frame_addr) && !seq_done && !word_ready));
endmodule

bind cfg_frame_addr_seq cfa_checker #(.FRAME_WORDS(FRAME_WORDS), .FA_W(cfa_pkg::FA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .word_valid(word_valid), .word_enable(word_enable), .word_ready(word_ready),
   .frame_addr(frame_addr), .seq_done(seq_done)
);

// File: tb/cfg_frame_addr_seq_test.sv
module cfg_frame_addr_seq_test;
   localparam int FW   = 41;
   localparam int CL   = 2;
   localparam int RL   = 1;
   localparam int M0   = 21;
   localparam int M1   = 19;
   localparam int M2   = 63;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [22:0] wr_addr = '0;
   logic        word_valid = 1'b0;
   logic        word_enable = 1'b0;
   logic        word_ready;
   logic [22:0] frame_addr;
   logic        seq_done;

   int n_run = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   cfg_frame_addr_seq #(
      .FRAME_WORDS(FW), .COL_LAST(CL), .ROW_LAST(RL), .TYPE_LAST(4),
      .MINOR_LAST_T0(M0), .MINOR_LAST_T1(M1), .MINOR_LAST_T2(M2),
      .MINOR_LAST_T3(M0), .MINOR_LAST_T4(M1)
   ) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .word_valid(word_valid), .word_enable(word_enable), .word_ready(word_ready),
      .frame_addr(frame_addr), .seq_done(seq_done)
   );

   function automatic logic [22:0] fa(input int h, input int t, input int r,
                                      input int c, input int m);
      return {1'(h), 3'(t), 5'(r), 8'(c), 6'(m)};
   endfunction

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic write_addr(input logic [22:0] a);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic send_words(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         word_valid = 1'b1; word_enable = 1'b1;
      end
      @(negedge clk);
      word_valid = 1'b0; word_enable = 1'b0;
   endtask

   task automatic t_reset;
      check("R1 addr", 32'(frame_addr), 0);
      check("R1 ready", 32'(word_ready), 1);
      check("R1 done", 32'(seq_done), 0);
   endtask

   task automatic t_write;
      write_addr(fa(1, 1, 1, 1, 5));
      check("R2 load", 32'(frame_addr), 32'(fa(1, 1, 1, 1, 5)));
      write_addr(fa(0, 0, 0, 0, 0));
      check("R2 load zero", 32'(frame_addr), 0);
   endtask

   task automatic t_frame_len;
      write_addr(fa(0, 0, 0, 0, 0));
      send_words(FW - 1);
      check("R3 hold at 40", 32'(frame_addr), 0);
      send_words(1);
      check("R3 step at 41", 32'(frame_addr), 32'(fa(0, 0, 0, 0, 1)));
   endtask

   task automatic t_write_clears;
      write_addr(fa(0, 0, 0, 0, 3));
      send_words(20);
      write_addr(fa(0, 1, 0, 1, 4));
      send_words(FW - 1);
      check("R2 count cleared", 32'(frame_addr), 32'(fa(0, 1, 0, 1, 4)));
      send_words(1);
      check("R2 full frame", 32'(frame_addr), 32'(fa(0, 1, 0, 1, 5)));
   endtask

   task automatic t_gating;
      write_addr(fa(0, 0, 0, 0, 0));
      @(negedge clk); word_valid = 1'b1; word_enable = 1'b0;
      repeat (50) @(negedge clk);
      word_valid = 1'b0; word_enable = 1'b1;
      repeat (50) @(negedge clk);
      word_enable = 1'b0;
      check("R4 no count", 32'(frame_addr), 0);
      send_words(FW - 1);
      check("R4 still held", 32'(frame_addr), 0);
      send_words(1);
      check("R4 counted", 32'(frame_addr), 32'(fa(0, 0, 0, 0, 1)));
   endtask

   task automatic t_minor;
      write_addr(fa(0, 0, 0, 0, M0));
      send_words(FW);
      check("R5 type0 wrap", 32'(frame_addr), 32'(fa(0, 0, 0, 1, 0)));
      write_addr(fa(0, 1, 0, 0, M1));
      send_words(FW);
      check("R5 type1 wrap", 32'(frame_addr), 32'(fa(0, 1, 0, 1, 0)));
      write_addr(fa(0, 2, 0, 0, M1));
      send_words(FW);
      check("R5 type2 no wrap at 19", 32'(frame_addr), 32'(fa(0, 2, 0, 0, M1 + 1)));
      write_addr(fa(0, 2, 0, 0, M2));
      send_words(FW);
      check("R5 type2 wrap", 32'(frame_addr), 32'(fa(0, 2, 0, 1, 0)));
   endtask

   task automatic t_col_row;
      write_addr(fa(0, 0, 0, CL, M0));
      send_words(FW);
      check("R6 col to row", 32'(frame_addr), 32'(fa(0, 0, 1, 0, 0)));
      write_addr(fa(0, 0, RL, CL, M0));
      send_words(FW);
      check("R6 row to half", 32'(frame_addr), 32'(fa(1, 0, 0, 0, 0)));
   endtask

   task automatic t_type;
      write_addr(fa(1, 0, RL, CL, M0));
      send_words(FW);
      check("R7 half to type", 32'(frame_addr), 32'(fa(0, 1, 0, 0, 0)));
      write_addr(fa(1, 1, RL, CL, M1));
      send_words(FW);
      check("R7 type1 to type2", 32'(frame_addr), 32'(fa(0, 2, 0, 0, 0)));
   endtask

   task automatic t_done;
      write_addr(fa(1, 2, RL, CL, M2));
      send_words(FW - 1);
      check("R8 no early done", 32'(seq_done), 0);
      send_words(1);
      check("R8 done pulse", 32'(seq_done), 1);
      check("R8 addr held", 32'(frame_addr), 32'(fa(1, 2, RL, CL, M2)));
      check("R8 ready low", 32'(word_ready), 0);
      @(negedge clk);
      check("R8 pulse one cycle", 32'(seq_done), 0);
      send_words(2 * FW);
      check("R8 words ignored", 32'(frame_addr), 32'(fa(1, 2, RL, CL, M2)));
      check("R8 no second done", 32'(seq_done), 0);
      write_addr(fa(0, 0, 0, 0, 0));
      check("R8 ready after write", 32'(word_ready), 1);
   endtask

   task automatic t_collide;
      write_addr(fa(0, 0, 0, 0, 7));
      send_words(FW - 1);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = fa(0, 1, 1, 0, 2);
      word_valid = 1'b1; word_enable = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; word_valid = 1'b0; word_enable = 1'b0;
      check("R9 write wins", 32'(frame_addr), 32'(fa(0, 1, 1, 0, 2)));
      send_words(FW - 1);
      check("R9 word not counted", 32'(frame_addr), 32'(fa(0, 1, 1, 0, 2)));
      send_words(1);
      check("R9 then steps", 32'(frame_addr), 32'(fa(0, 1, 1, 0, 3)));
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            @(negedge clk);
            t_reset();
            t_write();
            t_frame_len();
            t_write_clears();
            t_gating();
            t_minor();
            t_col_row();
            t_type();
            t_done();
            t_collide();
         end
         begin
            repeat (150000) @(posedge clk);
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      disable fork;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule